// File: doc/BRIEF.md
# Level-Match GPIO Controller

A 32-pin general-purpose I/O controller reached through a simple word-addressed register bus. Each pin is either under software control or handed to an on-chip alternate function. Software chooses this with the function-select register. In GPIO mode the pin's direction comes from the direction register and its driven value from the output-data register. In alternate mode the pin's direction is fixed per pin by a design parameter, and its value comes from the peripheral.

Pin inputs go through a two-flop synchroniser. The synchronised values feed the data read path, the alternate-function input vector and a per-pin level comparator. A status bit is captured whenever its pin sits at the level programmed for it. The bit then holds until software clears it. Two interrupt lines are formed from the status bits: one for the pins routed to the non-maskable line, and one for all the others.

Top module: `gpio_lvl_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x00 function select, 0x04 direction, 0x08 data, 0x0C match level, 0x10 status, 0x14 non-maskable route. Function, direction, level and route read back the last value written to them. A read of any other offset, or of an offset that is not a multiple of 4, returns 0, and a write there changes nothing.
- R2: A pin whose function bit is 0 is in GPIO mode. Its pad_oe_o bit equals its direction bit (1 = output), and its pad_out_o bit equals the bit last written to offset 0x08.
- R3: A pin whose function bit is 1 is in alternate mode. Its pad_oe_o bit comes from the ALT_OUT_MASK parameter, and its pad_out_o bit equals its alt_out_i bit; its direction and data bits are ignored. The default mask 0x0000_21F5 makes pins 0, 2, 4 to 8 and 13 outputs and every other pin an input.
- R4: A change on pin_i shows up in the offset 0x08 read and on alt_in_o after the second rising clock edge, and not before.
- R5: Status bit x is set on the rising edge after the synchronised value of pin x equals level bit x. For a pin change, that is the third rising edge.
- R6: A set status bit stays set after the match goes away. It is cleared only by writing 0 to that bit at offset 0x10; writing 1 leaves the bit as it was.
- R7: If the match still holds in the cycle of a clearing write, the status bit stays set.
- R8: nmi_o is high when some status bit has its route bit set. irq_o is high when some status bit has its route bit clear.
- R9: While rst_ni is low, all registers read 0 and pad_oe_o, pad_out_o, irq_o and nmi_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Bus access valid |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from offset |
| pin_i | input | 32 | Pad input values |
| pad_oe_o | output | 32 | Pad output enable per pin |
| pad_out_o | output | 32 | Pad output value per pin |
| alt_out_i | input | 32 | Values from alternate-function peripherals |
| alt_in_o | output | 32 | Synchronised pin values to peripherals |
| irq_o | output | 1 | Maskable interrupt |
| nmi_o | output | 1 | Non-maskable interrupt |

## Verification
The bench samples the status register one edge at a time after a pin change. A design with one synchroniser stage too few or too many therefore sets the bit a cycle early or late. It writes 0 to a status bit while the match still holds, which catches a design that lets the clear win. It also writes 1 to a status bit, which catches a design that treats 1 as a clear. It mixes GPIO and alternate pins in one function word with a direction word that conflicts with the alternate-mode directions. A design that lets the direction bit override alternate mode would then drive the wrong pad enables. It also writes to an unused offset and reads back function select, so a design that aliases that offset would corrupt function select.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
  typedef enum logic [2:0] {
    IDX_FUNC  = 3'd0,
    IDX_DIR   = 3'd1,
    IDX_DATA  = 3'd2,
    IDX_LEVEL = 3'd3,
    IDX_STAT  = 3'd4,
    IDX_ROUTE = 3'd5
  } reg_idx_e;

  localparam int unsigned NUM_REGS = 6;
  localparam logic [31:0] ALT_OUT_DEFAULT = 32'h0000_21F5;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_lvl_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      pin_sync_i,
  output logic [W-1:0]      func_o,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      dout_o,
  output logic [W-1:0]      level_o,
  output logic [W-1:0]      status_o,
  output logic [W-1:0]      route_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned, hit, wr;
  logic [W-1:0]     func_q, dir_q, dout_q, level_q, status_q, route_q;
  logic [W-1:0]     match, keep_mask;

  assign idx     = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign hit     = aligned && (idx < IDX_W'(NUM_REGS));
  assign wr      = sel_i && we_i && hit;

  assign match     = ~(pin_sync_i ^ level_q);
  // zero bits in a status write clear; ones keep
  assign keep_mask = (wr && idx == IDX_W'(IDX_STAT)) ? wdata_i : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      func_q   <= '0;
      dir_q    <= '0;
      dout_q   <= '0;
      level_q  <= '0;
      status_q <= '0;
      route_q  <= '0;
    end else begin
      status_q <= (status_q & keep_mask) | match;
      if (wr) begin
        unique case (idx)
          IDX_W'(IDX_FUNC):  func_q  <= wdata_i;
          IDX_W'(IDX_DIR):   dir_q   <= wdata_i;
          IDX_W'(IDX_DATA):  dout_q  <= wdata_i;
          IDX_W'(IDX_LEVEL): level_q <= wdata_i;
          IDX_W'(IDX_ROUTE): route_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      unique case (idx)
        IDX_W'(IDX_FUNC):  rdata_o = func_q;
        IDX_W'(IDX_DIR):   rdata_o = dir_q;
        IDX_W'(IDX_DATA):  rdata_o = pin_sync_i;
        IDX_W'(IDX_LEVEL): rdata_o = level_q;
        IDX_W'(IDX_STAT):  rdata_o = status_q;
        IDX_W'(IDX_ROUTE): rdata_o = route_q;
        default:           rdata_o = '0;
      endcase
    end
  end

  assign func_o   = func_q;
  assign dir_o    = dir_q;
  assign dout_o   = dout_q;
  assign level_o  = level_q;
  assign status_o = status_q;
  assign route_o  = route_q;
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int unsigned W            = 32,
  parameter logic [W-1:0] ALT_OUT_MASK = '0
) (
  input  logic [W-1:0] func_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] dout_i,
  input  logic [W-1:0] alt_out_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] out_o
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    if (ALT_OUT_MASK[p]) begin : g_alt_out
      assign oe_o[p] = func_i[p] | dir_i[p];
    end else begin : g_alt_in
      assign oe_o[p] = ~func_i[p] & dir_i[p];
    end
    assign out_o[p] = func_i[p] ? alt_out_i[p] : dout_i[p];
  end
endmodule

// File: rtl/gpio_lvl_ctrl.sv
module gpio_lvl_ctrl
  import gpio_lvl_pkg::*;
#(
  parameter int unsigned NPINS        = 32,
  parameter int unsigned ADDR_W       = 5,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter logic [NPINS-1:0] ALT_OUT_MASK = NPINS'(ALT_OUT_DEFAULT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NPINS-1:0]  bus_wdata_i,
  output logic [NPINS-1:0]  bus_rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pad_oe_o,
  output logic [NPINS-1:0]  pad_out_o,
  input  logic [NPINS-1:0]  alt_out_i,
  output logic [NPINS-1:0]  alt_in_o,
  output logic              irq_o,
  output logic              nmi_o
);
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] func_q, dir_q, dout_q, level_q, status_q, route_q;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  gpio_regs #(.W(NPINS), .ADDR_W(ADDR_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (bus_sel_i),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .rdata_o    (bus_rdata_o),
    .pin_sync_i (pin_sync),
    .func_o     (func_q),
    .dir_o      (dir_q),
    .dout_o     (dout_q),
    .level_o    (level_q),
    .status_o   (status_q),
    .route_o    (route_q)
  );

  gpio_pad_mux #(.W(NPINS), .ALT_OUT_MASK(ALT_OUT_MASK)) i_mux (
    .func_i    (func_q),
    .dir_i     (dir_q),
    .dout_i    (dout_q),
    .alt_out_i (alt_out_i),
    .oe_o      (pad_oe_o),
    .out_o     (pad_out_o)
  );

  assign alt_in_o = pin_sync;
  assign nmi_o    = |(status_q & route_q);
  assign irq_o    = |(status_q & ~route_q);
endmodule

// File: rtl/gpio_lvl_ctrl_chk.sv
module gpio_lvl_ctrl_chk #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 5,
  parameter logic [NPINS-1:0] ALT_OUT_MASK = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [NPINS-1:0]  bus_wdata_i,
  input logic [NPINS-1:0]  pin_sync,
  input logic [NPINS-1:0]  func_q,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  level_q,
  input logic [NPINS-1:0]  status_q,
  input logic [NPINS-1:0]  route_q,
  input logic [NPINS-1:0]  pad_oe_o,
  input logic [NPINS-1:0]  pad_out_o,
  input logic [NPINS-1:0]  alt_out_i,
  input logic              irq_o,
  input logic              nmi_o
);
  localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(16);

  logic             stat_wr;
  logic [NPINS-1:0] match;
  assign stat_wr = bus_sel_i && bus_we_i && (bus_addr_i == STAT_OFS);
  assign match   = ~(pin_sync ^ level_q);

  p_gpio_oe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o ^ dir_q) & ~func_q) == '0);

  p_alt_oe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o ^ ALT_OUT_MASK) & func_q) == '0);

  p_alt_out_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_out_o ^ alt_out_i) & func_q) == '0);

  // R7 as well: a match sets the bit even in a clearing cycle
  p_match_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(match)) == $past(match)));

  p_sticky_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_wr |=> (($past(status_q) & ~status_q) == '0));

  p_clear_by_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr |=> (($past(status_q) & ~status_q & $past(bus_wdata_i)) == '0));

  p_idle_lines_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q == '0) |-> (!irq_o && !nmi_o));

  p_nmi_route_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & route_q) != '0) |-> nmi_o);
endmodule

bind gpio_lvl_ctrl gpio_lvl_ctrl_chk #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .ALT_OUT_MASK(ALT_OUT_MASK)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_sel_i   (bus_sel_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .pin_sync    (pin_sync),
  .func_q      (func_q),
  .dir_q       (dir_q),
  .level_q     (level_q),
  .status_q    (status_q),
  .route_q     (route_q),
  .pad_oe_o    (pad_oe_o),
  .pad_out_o   (pad_out_o),
  .alt_out_i   (alt_out_i),
  .irq_o       (irq_o),
  .nmi_o       (nmi_o)
);

// File: tb/test_gpio_lvl_ctrl.sv
module test_gpio_lvl_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] pin = '0, alt_out = '0;
  logic [31:0] pad_oe, pad_out, alt_in;
  logic        irq, nmi;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  gpio_lvl_ctrl i_gpio_lvl_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_i(pin), .pad_oe_o(pad_oe), .pad_out_o(pad_out),
    .alt_out_i(alt_out), .alt_in_o(alt_in),
    .irq_o(irq), .nmi_o(nmi)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  ofs;
    logic [31:0] dat;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'h00, 32'h1234_5678},
    '{1'b0, 5'h00, 32'h1234_5678},
    '{1'b1, 5'h04, 32'hCAFE_0001},
    '{1'b0, 5'h04, 32'hCAFE_0001},
    '{1'b1, 5'h0C, 32'h0F0F_F0F0},
    '{1'b0, 5'h0C, 32'h0F0F_F0F0},
    '{1'b1, 5'h14, 32'h8000_0003},
    '{1'b0, 5'h14, 32'h8000_0003},
    '{1'b0, 5'h18, 32'h0000_0000},
    '{1'b0, 5'h1C, 32'h0000_0000},
    '{1'b1, 5'h18, 32'hDEAD_BEEF},
    '{1'b1, 5'h01, 32'h5555_5555},
    '{1'b0, 5'h00, 32'h1234_5678},
    '{1'b0, 5'h02, 32'h0000_0000}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_wr(logic [4:0] a, logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    step();
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(logic [4:0] a, output logic [31:0] d);
    addr = a; sel = 1'b1; we = 1'b0;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  logic [31:0] rv;

  initial begin
    // R9: reset state
    repeat (2) step();
    bus_rd(5'h10, rv); chk("R9 status in reset", rv, 32'h0);
    bus_rd(5'h00, rv); chk("R9 func in reset", rv, 32'h0);
    chk("R9 pad_oe in reset", pad_oe, 32'h0);
    chk("R9 irq/nmi in reset", {30'h0, irq, nmi}, 32'h0);
    rst_n = 1'b1;
    step();

    // R1: register table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) bus_wr(VEC[i].ofs, VEC[i].dat);
      else begin
        bus_rd(VEC[i].ofs, rv);
        chk($sformatf("R1 read ofs %02h", VEC[i].ofs), rv, VEC[i].dat);
      end
    end

    // R2: all GPIO
    bus_wr(5'h00, 32'h0);
    bus_wr(5'h04, 32'h0000_FFFF);
    bus_wr(5'h08, 32'h0000_00FF);
    alt_out = 32'hAAAA_5555;
    #1;
    chk("R2 gpio oe", pad_oe, 32'h0000_FFFF);
    chk("R2 gpio out", pad_out, 32'h0000_00FF);
    // R3: all alternate
    bus_wr(5'h00, 32'hFFFF_FFFF);
    chk("R3 alt oe", pad_oe, 32'h0000_21F5);
    chk("R3 alt out", pad_out, 32'hAAAA_5555);
    // R2/R3 mixed: pins 4-7 alternate
    bus_wr(5'h00, 32'h0000_00F0);
    chk("R3 mixed oe", pad_oe, 32'h0000_FFFF);
    chk("R3 mixed out", pad_out, 32'h0000_005F);
    bus_wr(5'h04, 32'h0000_0000);
    chk("R3 alt oe ignores dir", pad_oe, 32'h0000_00F0);

    // prepare status: no pin matches
    bus_wr(5'h0C, 32'hFFFF_FFFF);
    bus_wr(5'h14, 32'h0);
    bus_wr(5'h10, 32'h0);
    step();
    bus_rd(5'h10, rv); chk("R6 cleared status", rv, 32'h0);
    chk("R8 lines idle", {30'h0, irq, nmi}, 32'h0);

    // R4/R5 latency
    pin = 32'h0000_0020;
    step();
    bus_rd(5'h08, rv); chk("R4 data after 1 edge", rv, 32'h0);
    step();
    bus_rd(5'h08, rv); chk("R4 data after 2 edges", rv, 32'h20);
    chk("R4 alt_in after 2 edges", alt_in, 32'h20);
    bus_rd(5'h10, rv); chk("R5 status after 2 edges", rv, 32'h0);
    step();
    bus_rd(5'h10, rv); chk("R5 status after 3 edges", rv, 32'h20);
    chk("R8 irq on unrouted", {30'h0, irq, nmi}, 32'h2);
    bus_wr(5'h14, 32'h0000_0020);
    chk("R8 nmi on routed", {30'h0, irq, nmi}, 32'h1);

    // R6 sticky
    pin = 32'h0;
    repeat (3) step();
    bus_rd(5'h10, rv); chk("R6 sticky after match gone", rv, 32'h20);
    bus_wr(5'h10, 32'hFFFF_FFFF);
    bus_rd(5'h10, rv); chk("R6 write 1 keeps", rv, 32'h20);
    bus_wr(5'h10, 32'h0);
    bus_rd(5'h10, rv); chk("R6 write 0 clears", rv, 32'h0);
    chk("R8 lines idle after clear", {30'h0, irq, nmi}, 32'h0);

    // R7 set wins over clear
    pin = 32'h0000_0040;
    repeat (3) step();
    bus_rd(5'h10, rv); chk("R5 second pin set", rv, 32'h40);
    bus_wr(5'h10, 32'h0);
    bus_rd(5'h10, rv); chk("R7 set beats clear", rv, 32'h40);
    chk("R8 irq only", {30'h0, irq, nmi}, 32'h2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule